// File: doc/BRIEF.md
# Backup Watchdog Timer

This block is a down-counting watchdog with a small register port. Software programs a modulus and a control word once after power-up. While the watchdog is enabled the counter steps down on every clock where the `tick` input is high. If the counter reaches zero before software services it, the block raises a one-cycle reset request and starts again from the modulus. To service the watchdog, software writes a two-word key sequence to the service register, which reloads the counter.

The control and modulus registers are write-once. They keep their contents through a warm reset, and only a power-on reset returns them to their defaults. Three low-power mode inputs (wait, doze, stop) each have their own control bit. That bit selects whether the counter freezes or keeps running while the device is in that mode. A frozen counter picks up again from the exact value it held. A warm reset reloads the counter from the retained modulus and discards any half-finished service sequence.

Top module: `bkp_watchdog`

## Requirements
- R1: After power-on reset the registers read as follows: control 0x02, modulus equal to the `MOD_RST` parameter (0xFFFF by default), count equal to that modulus, and service 0x0000.
- R2: Registers are selected by the byte offset on `bus_addr`: control at 0x0, modulus at 0x2, count at 0x4 and service at 0x6. Control bit 0 is the enable. Bits 1, 2 and 3 freeze the counter in wait, doze and stop mode respectively. Control bits 7..4 always read 0, and the service register always reads 0.
- R3: The control and modulus registers each accept only their first write after power-on reset. Every later write to them is ignored until the next power-on reset.
- R4: A warm reset leaves the control and modulus contents and their write locks unchanged. A power-on reset restores both registers to their defaults and unlocks them.
- R5: While enabled and not frozen, the count drops by one on every clock where `tick` is 1. It holds on every clock where `tick` is 0.
- R6: If the count is 0 on a running tick, the counter reloads from the modulus. `wdog_req` is then 1 for exactly the next cycle. With modulus M, the request comes M+1 running ticks after a reload.
- R7: While a mode input is 1 and its control bit is 1, the count holds. While a mode input is 1 and its control bit is 0, the count keeps decrementing.
- R8: When a freeze ends, counting resumes from the held value, with no reload.
- R9: Writing 0x5555 and then 0xAAAA to the service register reloads the count from the modulus on the 0xAAAA write.
- R10: Any service write other than 0x5555 clears a pending 0x5555. A 0xAAAA write with no pending 0x5555 does not reload the counter.
- R11: Writes to the count register have no effect.
- R12: A warm reset reloads the count from the retained modulus and clears a pending 0x5555.
- R13: While the enable bit is 0, the count holds its value and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_n | input | 1 | Warm reset, asynchronous, active low |
| tick | input | 1 | Count enable strobe |
| wait_mode | input | 1 | Device is in wait mode |
| doze_mode | input | 1 | Device is in doze mode |
| stop_mode | input | 1 | Device is in stop mode |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the register at `bus_addr` |
| wdog_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with `DW` = 16 and with `MOD_RST` lowered to 0x0030. This keeps the defaults visible after power-on reset and lets the bench tell them apart from the value it programs later. The bench locks the modulus at 0x0100, so a full expiry takes 257 ticks. Each cycle of the reload-to-request interval can then be counted exactly. Mode inputs and `tick` are switched in single cycles, so freeze, resume and service outcomes appear as exact count values read back through the bus.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  // Register word index, taken from bus_addr[2:1]
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_MOD  = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_SVC  = 2'd3;
  localparam int         NUM_REGS = 4;

  // Control word layout
  localparam int CB_EN     = 0;
  localparam int CB_WAIT   = 1;
  localparam int CB_DOZE   = 2;
  localparam int CB_STOP   = 3;
  localparam int CTRL_USED = 4;
  localparam logic [CTRL_USED-1:0] CTRL_RST = 4'b0010;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } svc_state_e;

endpackage

// File: rtl/bwd_rst_sync.sv
module bwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  generate
    if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= 1'b0;
        else         s_q <= 1'b1;
      end
      assign rst_n_o = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_o = s_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
#(
  parameter int             DW      = 16,
  parameter logic [DW-1:0]  MOD_RST = '1
) (
  input  logic                 clk,
  input  logic                 por_rst_n,
  input  logic                 ctrl_wr,
  input  logic                 mod_wr,
  input  logic [DW-1:0]        wdata,
  output logic [CTRL_USED-1:0] ctrl_o,
  output logic [DW-1:0]        mod_o
);

  logic [CTRL_USED-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]        mod_q, mod_d;
  logic                 ctrl_lock_q, mod_lock_q;
  logic                 ctrl_en, mod_en;

  // First write after power-on wins; the lock bit closes the register
  assign ctrl_en = ctrl_wr && !ctrl_lock_q;
  assign mod_en  = mod_wr  && !mod_lock_q;

  always_comb begin
    ctrl_d = wdata[CTRL_USED-1:0];
    mod_d  = wdata;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      ctrl_q      <= CTRL_RST;
      ctrl_lock_q <= 1'b0;
    end else if (ctrl_en) begin
      ctrl_q      <= ctrl_d;
      ctrl_lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      mod_q      <= MOD_RST;
      mod_lock_q <= 1'b0;
    end else if (mod_en) begin
      mod_q      <= mod_d;
      mod_lock_q <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (ctrl_lock_q && ctrl_wr) |=> $stable(ctrl_q)); // R3
  AST_MOD_LOCKED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (mod_lock_q && mod_wr) |=> $stable(mod_q)); // R3

endmodule

// File: rtl/bwd_service.sv
module bwd_service
  import bwd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          svc_wr,
  input  logic [DW-1:0] wdata,
  output logic          reload_o
);

  localparam logic [DW-1:0] KEY_ARM  = {(DW/2){2'b01}};
  localparam logic [DW-1:0] KEY_FIRE = {(DW/2){2'b10}};

  svc_state_e state_q, state_d;
  logic       reload_d;

  always_comb begin
    state_d  = state_q;
    reload_d = 1'b0;
    if (svc_wr) begin
      if (wdata == KEY_ARM) begin
        state_d = SVC_ARMED;
      end else if (state_q == SVC_ARMED && wdata == KEY_FIRE) begin
        reload_d = 1'b1;
        state_d  = SVC_IDLE;
      end else begin
        state_d = SVC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SVC_IDLE;
    else if (svc_wr) state_q <= state_d;
  end

  assign reload_o = reload_d;

  AST_SVC_BAD_KEY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && wdata != KEY_ARM && wdata != KEY_FIRE) |=> (state_q == SVC_IDLE)); // R10

endmodule

// File: rtl/bwd_counter.sv
module bwd_counter
  import bwd_pkg::*;
#(
  parameter int             DW      = 16,
  parameter logic [DW-1:0]  MOD_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [CTRL_USED-1:0] ctrl,
  input  logic                 wait_mode,
  input  logic                 doze_mode,
  input  logic                 stop_mode,
  input  logic                 svc_reload,
  input  logic [DW-1:0]        modulus,
  output logic [DW-1:0]        cnt_o,
  output logic                 req_o
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          pend_q;
  logic          req_q, req_d;
  logic [2:0]    mode_vec, mask_vec;
  logic          freeze, run, cnt_en;

  assign mode_vec = {stop_mode, doze_mode, wait_mode};
  assign mask_vec = {ctrl[CB_STOP], ctrl[CB_DOZE], ctrl[CB_WAIT]};
  assign freeze   = |(mode_vec & mask_vec);
  assign run      = ctrl[CB_EN] && tick && !freeze;
  assign cnt_en   = pend_q || svc_reload || run;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (pend_q || svc_reload) begin
      cnt_d = modulus;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_d = modulus;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // The load-pending flag picks up the retained modulus right after any reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= MOD_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0 && !svc_reload && !pend_q) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_REQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(cnt_q) == '0 && cnt_q == $past(modulus))); // R6
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !svc_reload && !pend_q) |=> $stable(cnt_q)); // R7
  AST_SVC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_reload |=> (cnt_q == $past(modulus))); // R9
  AST_RESET_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (cnt_q == $past(modulus))); // R12
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_EN] && !svc_reload && !pend_q) |=> ($stable(cnt_q) && !req_q)); // R13

endmodule

// File: rtl/bkp_watchdog.sv
module bkp_watchdog
  import bwd_pkg::*;
#(
  parameter int             DW      = 16,
  parameter int             ADDR_W  = 3,
  parameter logic [DW-1:0]  MOD_RST = '1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              tick,
  input  logic              wait_mode,
  input  logic              doze_mode,
  input  logic              stop_mode,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wdog_req
);

  localparam int PAD_W = DW - CTRL_USED;

  logic                 por_sync_n, warm_sync_n, core_rst_n, warm_arst_n;
  logic [NUM_REGS-1:0]  wr_sel;
  logic [1:0]           widx;
  logic [CTRL_USED-1:0] ctrl;
  logic [DW-1:0]        modulus, count;
  logic                 svc_reload;

  assign warm_arst_n = por_n && warm_n;

  bwd_rst_sync #(.STAGES(2)) u_por_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (por_sync_n)
  );

  bwd_rst_sync #(.STAGES(2)) u_warm_sync (
    .clk     (clk),
    .arst_n  (warm_arst_n),
    .rst_n_o (warm_sync_n)
  );

  assign core_rst_n = por_sync_n && warm_sync_n;

  // Word-aligned decode: one strobe per register slot
  assign widx = bus_addr[2:1];
  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_sel[i] = bus_we && !bus_addr[0] && (widx == i[1:0]);
    end
  endgenerate

  bwd_cfg_regs #(.DW(DW), .MOD_RST(MOD_RST)) u_cfg (
    .clk       (clk),
    .por_rst_n (por_sync_n),
    .ctrl_wr   (wr_sel[IDX_CTRL]),
    .mod_wr    (wr_sel[IDX_MOD]),
    .wdata     (bus_wdata),
    .ctrl_o    (ctrl),
    .mod_o     (modulus)
  );

  bwd_service #(.DW(DW)) u_svc (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .svc_wr   (wr_sel[IDX_SVC]),
    .wdata    (bus_wdata),
    .reload_o (svc_reload)
  );

  bwd_counter #(.DW(DW), .MOD_RST(MOD_RST)) u_cnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick       (tick),
    .ctrl       (ctrl),
    .wait_mode  (wait_mode),
    .doze_mode  (doze_mode),
    .stop_mode  (stop_mode),
    .svc_reload (svc_reload),
    .modulus    (modulus),
    .cnt_o      (count),
    .req_o      (wdog_req)
  );

  // The count slot has no write path, so wr_sel[IDX_CNT] drives nothing
  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[0]) begin
      case (widx)
        IDX_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl};
        IDX_MOD:  bus_rdata = modulus;
        IDX_CNT:  bus_rdata = count;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wdog_req && modulus != '0) |=> !wdog_req); // R6
  AST_CNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_sel[IDX_CNT] && !ctrl[CB_EN]) |=> $stable(count)); // R11

endmodule

// File: tb/bkp_watchdog_test.sv
module bkp_watchdog_test;

  localparam int DW = 16;
  localparam logic [2:0] A_CTRL = 3'h0, A_MOD = 3'h2, A_CNT = 3'h4, A_SVC = 3'h6;

  logic clk, por_n, warm_n, tick, wait_mode, doze_mode, stop_mode, bus_we;
  logic [2:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          wdog_req;

  bkp_watchdog #(.DW(DW), .ADDR_W(3), .MOD_RST(16'h0030)) uut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .tick(tick),
    .wait_mode(wait_mode), .doze_mode(doze_mode), .stop_mode(stop_mode),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdog_req(wdog_req)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic rd_act;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read against the queued expectation
  always @(posedge clk) begin
    #3ns;
    if (rd_act && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic op_idle(input int n);
    repeat (n) begin
      @(posedge clk); #1ns;
      bus_we = 0; rd_act = 0;
    end
  endtask

  task automatic op_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1ns;
    rd_act = 0; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic op_rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    @(posedge clk); #1ns;
    bus_we = 0; bus_addr = a; rd_act = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic set_modes(input logic w, input logic d, input logic s, input logic t);
    @(posedge clk); #1ns;
    bus_we = 0; rd_act = 0;
    wait_mode = w; doze_mode = d; stop_mode = s; tick = t;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 0; warm_n = 0; tick = 1; wait_mode = 0; doze_mode = 0; stop_mode = 0;
    bus_we = 0; bus_addr = '0; bus_wdata = '0; rd_act = 0;
    op_idle(4);
    por_n = 1; warm_n = 1;
    op_idle(6);

    // Reset state (R1) and read-only slots (R2)
    op_rd(A_CTRL, 16'h0002, "R1 ctrl reset");
    op_rd(A_MOD,  16'h0030, "R1 mod reset");
    op_rd(A_CNT,  16'h0030, "R1 count reset");
    op_rd(A_SVC,  16'h0000, "R2 service reads 0");
    op_idle(3);
    op_rd(A_CNT,  16'h0030, "R13 disabled holds");
    op_wr(A_CNT,  16'h1234);
    op_rd(A_CNT,  16'h0030, "R11 count write ignored");

    // Write-once modulus (R3)
    op_wr(A_MOD, 16'h0100);
    op_rd(A_MOD, 16'h0100, "R3 first mod write");
    op_wr(A_MOD, 16'h0200);
    op_rd(A_MOD, 16'h0100, "R3 second mod write ignored");
    op_rd(A_CNT, 16'h0030, "R13 no reload on mod write");
    op_wr(A_SVC, 16'h5555);
    op_wr(A_SVC, 16'hAAAA);
    op_rd(A_CNT, 16'h0100, "R9 service reload");

    // Enable with wait and stop freeze bits, stop active
    set_modes(0, 0, 1, 1);
    op_wr(A_CTRL, 16'h000B);
    op_wr(A_CTRL, 16'h0000);
    op_rd(A_CTRL, 16'h000B, "R3 ctrl locked");
    op_rd(A_CNT,  16'h0100, "R7 stop frozen");      // c0
    set_modes(0, 0, 0, 1);                          // c1 runs
    op_idle(1);                                     // c2 runs
    set_modes(0, 0, 1, 1);                          // c3 frozen
    op_idle(3);
    op_rd(A_CNT, 16'h00FE, "R7 held during stop");  // c7
    set_modes(0, 0, 0, 1);                          // c8
    op_rd(A_CNT, 16'h00FD, "R8 resume no reload");  // c9
    set_modes(0, 1, 0, 1);                          // c10 doze bit 0 runs
    op_rd(A_CNT, 16'h00FB, "R7 doze not frozen");   // c11
    set_modes(1, 0, 0, 1);                          // c12 wait frozen
    op_rd(A_CNT, 16'h00FA, "R7 wait frozen");       // c13
    op_rd(A_CNT, 16'h00FA, "R7 wait still frozen"); // c14
    set_modes(0, 0, 0, 0);                          // c15 tick low
    op_rd(A_CNT, 16'h00FA, "R5 tick low holds");    // c16
    set_modes(0, 0, 0, 1);                          // c17
    op_rd(A_CNT, 16'h00F9, "R5 one per tick");      // c18

    // Broken service sequences (R10)
    op_wr(A_SVC, 16'h5555);
    op_wr(A_SVC, 16'h1234);
    op_wr(A_SVC, 16'hAAAA);
    op_rd(A_CNT, 16'h00F5, "R10 broken sequence no reload");
    op_wr(A_SVC, 16'hAAAA);
    op_rd(A_CNT, 16'h00F3, "R10 unarmed key no reload");
    op_wr(A_SVC, 16'h5555);
    op_wr(A_SVC, 16'hAAAA);
    op_rd(A_CNT, 16'h0100, "R9 running service reload");

    // Expiry timing (R6)
    begin
      int n;
      n = 0;
      do begin
        op_idle(1); #2ns; n++;
      end while (!wdog_req && n < 400);
      check("R6 ticks to request", DW'(n), 16'd257);
      op_rd(A_CNT, 16'h00FF, "R6 reload after expiry");
      #2ns;
      check("R6 request one cycle", {15'd0, wdog_req}, 16'd0);
    end

    // Warm reset (R12, R4)
    set_modes(0, 0, 1, 1);
    op_wr(A_SVC, 16'h5555);
    @(posedge clk); #1ns; bus_we = 0; warm_n = 0;
    op_idle(3);
    warm_n = 1;
    op_idle(6);
    op_rd(A_CNT, 16'h0100, "R12 warm reload");
    set_modes(0, 0, 0, 1);
    set_modes(0, 0, 1, 1);
    op_wr(A_SVC, 16'hAAAA);
    op_rd(A_CNT,  16'h00FF, "R12 pending key cleared");
    op_rd(A_CTRL, 16'h000B, "R4 ctrl kept over warm");
    op_rd(A_MOD,  16'h0100, "R4 mod kept over warm");
    op_wr(A_MOD,  16'h0020);
    op_rd(A_MOD,  16'h0100, "R4 lock kept over warm");

    // Power-on reset (R4, R3, R2)
    @(posedge clk); #1ns; por_n = 0;
    op_idle(3);
    por_n = 1;
    op_idle(6);
    op_rd(A_CTRL, 16'h0002, "R4 ctrl restored by por");
    op_rd(A_MOD,  16'h0030, "R4 mod restored by por");
    op_rd(A_CNT,  16'h0030, "R1 count after por");
    op_wr(A_MOD,  16'h0040);
    op_rd(A_MOD,  16'h0040, "R3 unlocked after por");
    op_wr(A_CTRL, 16'h00F8);
    op_rd(A_CTRL, 16'h0008, "R2 reserved bits read 0");
    op_idle(2);

    check("queue drained", DW'(exp_q.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule